// File: doc/BRIEF.md
# Fixed-Ratio Cascaded Integrator-Comb Decimator

This block lowers the sample rate of a real 16-bit two's-complement stream by a fixed factor of 256. A 64 Msps input becomes a 250 ksps output. Six integrators run at the input rate and advance only on accepted samples. A counter of accepted samples marks every 256th one. On that mark, six first-difference comb stages run once and produce one output word. The full-precision result is cut to its top 16 bits by plain truncation, which gives the filter a DC gain of exactly one.

The input side has a data word and a valid flag, and every valid sample is taken. The output side has a data word and a one-cycle valid pulse, with no ready. A downstream consumer must take each word in the cycle its valid is high. A complex receiver uses two copies side by side, one for I and one for Q. Both copies get the same valid pattern, so their output pulses stay in lockstep.

Top module: `cic_decimator`

## Requirements
- R1: While `rst_n` is low and right after it is released, `m_valid` is 0 and `m_data` is 0; with an all-zero input every output word is 0.
- R2: `m_valid` is high for exactly one clock, in the cycle after every 256th sample accepted since reset, and low in every other cycle.
- R3: A cycle with `s_valid` low is ignored. Neither the `s_data` value in that cycle nor the gap changes the output words or the cadence of the output pulses.
- R4: For a constant input x held since reset, every output from the 13th onward equals x. The total gain is 256^6 = 2^48, and the low 48 bits of the 64-bit result are dropped.
- R5: Constant inputs of -32768 and +32767 both settle to exactly that value. Internal 64-bit integrators wrap modulo 2^64 without corrupting the result.
- R6: Truncation rounds toward minus infinity. The period-2 input 1,0,1,0… settles to 0, and the input -1,0,-1,0… settles to -1 (0xFFFF).
- R7: Two instances that see the same `s_valid` pattern raise `m_valid` in the same cycles, whatever their data.
- R8: `m_data` changes only in a cycle where `m_valid` is high, and holds its value between output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the input sample rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| s_data | input | 16 | Input sample, two's complement |
| s_valid | input | 1 | Input sample present this cycle; always accepted |
| m_data | output | 16 | Decimated sample, two's complement, truncated |
| m_valid | output | 1 | One-cycle pulse marking a new `m_data` |

## Verification
The properties assume that `s_valid` is 0 during reset. They also assume the input counts as accepted in every cycle where `s_valid` is high, because the output has no ready. The bench meets both conditions: it holds `s_valid` low during every reset, and its output monitor takes each word in the cycle of its pulse. Gaps in `s_valid` are placed on a fixed one-in-three pattern. During those gaps `s_data` carries a misleading full-scale value, so any leak into the result shows up in the steady-state words.

// File: rtl/cic_pkg.sv
package cic_pkg;
  // Register width that holds the worst-case growth of the whole cascade.
  function automatic int acc_width(int in_w, int stages, int rate_log2);
    return in_w + stages * rate_log2;
  endfunction
endpackage

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
  parameter int IN_W   = 16,
  parameter int ACC_W  = 64,
  parameter int STAGES = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [IN_W-1:0]  din,
  output logic [ACC_W-1:0] tail
);
  logic [ACC_W-1:0] acc_q [STAGES];
  logic [ACC_W-1:0] acc_d [STAGES];
  logic [ACC_W-1:0] feed  [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_feed
    if (g == 0) begin : g_head
      assign feed[g] = {{(ACC_W-IN_W){din[IN_W-1]}}, din};
    end else begin : g_link
      assign feed[g] = acc_q[g-1];
    end
  end

  always_comb begin
    for (int s = 0; s < STAGES; s++) begin
      acc_d[s] = en ? acc_q[s] + feed[s] : acc_q[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) acc_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) acc_q[s] <= acc_d[s];
    end
  end

  assign tail = acc_q[STAGES-1];
endmodule

// File: rtl/cic_rate_ctr.sv
module cic_rate_ctr #(
  parameter int RATE_LOG2 = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic dec_stb
);
  logic [RATE_LOG2-1:0] cnt_q;
  logic [RATE_LOG2-1:0] cnt_d;

  always_comb begin
    cnt_d = en ? cnt_q + 1'b1 : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign dec_stb = en && (cnt_q == {RATE_LOG2{1'b1}});
endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
  parameter int ACC_W  = 64,
  parameter int STAGES = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] din,
  output logic [ACC_W-1:0] dout
);
  logic [ACC_W-1:0] dly_q [STAGES];
  logic [ACC_W-1:0] dly_d [STAGES];
  logic [ACC_W-1:0] dif_q [STAGES];
  logic [ACC_W-1:0] dif_d [STAGES];
  logic [ACC_W-1:0] src   [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_src
    if (g == 0) begin : g_head
      assign src[g] = din;
    end else begin : g_link
      assign src[g] = dif_q[g-1];
    end
  end

  always_comb begin
    for (int s = 0; s < STAGES; s++) begin
      dly_d[s] = en ? src[s]             : dly_q[s];
      dif_d[s] = en ? src[s] - dly_q[s]  : dif_q[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        dly_q[s] <= '0;
        dif_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < STAGES; s++) begin
        dly_q[s] <= dly_d[s];
        dif_q[s] <= dif_d[s];
      end
    end
  end

  assign dout = dif_q[STAGES-1];
endmodule

// File: rtl/cic_decimator.sv
module cic_decimator
  import cic_pkg::*;
#(
  parameter int IN_W      = 16,
  parameter int OUT_W     = 16,
  parameter int STAGES    = 6,
  parameter int RATE_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  s_data,
  input  logic             s_valid,
  output logic [OUT_W-1:0] m_data,
  output logic             m_valid
);
  localparam int ACC_W = acc_width(IN_W, STAGES, RATE_LOG2);

  logic [ACC_W-1:0] integ_tail;
  logic [ACC_W-1:0] comb_tail;
  logic             dec_stb;
  logic             vld_q;
  logic             vld_d;

  cic_integ_chain #(.IN_W(IN_W), .ACC_W(ACC_W), .STAGES(STAGES)) u_integ (
    .clk(clk), .rst_n(rst_n), .en(s_valid), .din(s_data), .tail(integ_tail)
  );

  cic_rate_ctr #(.RATE_LOG2(RATE_LOG2)) u_rate (
    .clk(clk), .rst_n(rst_n), .en(s_valid), .dec_stb(dec_stb)
  );

  cic_comb_chain #(.ACC_W(ACC_W), .STAGES(STAGES)) u_comb (
    .clk(clk), .rst_n(rst_n), .en(dec_stb), .din(integ_tail), .dout(comb_tail)
  );

  always_comb vld_d = dec_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign m_valid = vld_q;
  assign m_data  = comb_tail[ACC_W-1 -: OUT_W];
endmodule

module cic_decimator_chk #(
  parameter int OUT_W     = 16,
  parameter int ACC_W     = 64,
  parameter int RATE_LOG2 = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid,
  input logic             m_valid,
  input logic [OUT_W-1:0] m_data,
  input logic [ACC_W-1:0] integ_tail
);
  logic [RATE_LOG2-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_q <= '0;
    else if (s_valid) seen_q <= seen_q + 1'b1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!m_valid && m_data == '0));

  assert_pulse_cadence_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid == ($past(s_valid) && $past(seen_q) == {RATE_LOG2{1'b1}}));

  assert_single_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |=> !m_valid);

  assert_gap_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid |=> $stable(integ_tail));

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(m_data) |-> m_valid);
endmodule

bind cic_decimator cic_decimator_chk #(
  .OUT_W(OUT_W), .ACC_W(ACC_W), .RATE_LOG2(RATE_LOG2)
) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .m_valid(m_valid),
  .m_data(m_data), .integ_tail(integ_tail)
);

// File: tb/sim_cic_decimator.sv
module sim_cic_decimator;
  localparam int CLK_NS = 10;
  localparam int RATIO  = 256;
  localparam int SETTLE = 12;
  localparam int NOUT   = 16;

  typedef struct {
    bit              chk;
    logic signed [15:0] val;
    string           tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] s_data = '0;
  logic [15:0] q_data = '0;
  logic        s_valid = 1'b0;
  logic [15:0] m_data, q_out;
  logic        m_valid, q_valid;

  int total = 0;
  int bad = 0;
  bit pending = 0;
  bit done = 0;
  exp_t sb[$];

  always #(CLK_NS/2) clk = ~clk;

  cic_decimator u0 (.clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid),
                    .m_data(m_data), .m_valid(m_valid));
  cic_decimator u1 (.clk(clk), .rst_n(rst_n), .s_data(q_data), .s_valid(s_valid),
                    .m_data(q_out), .m_valid(q_valid));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected words as the design emits them
  always @(negedge clk) begin
    if (rst_n && (m_valid || pending)) begin
      check(m_valid == pending, "R2 pulse timing", m_valid, pending);
      check(q_valid == m_valid, "R7 I/Q lockstep", q_valid, m_valid);
      if (m_valid && sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        if (e.chk) check($signed(m_data) == e.val, e.tag, $signed(m_data), e.val);
      end
      pending = 0;
    end else if (rst_n && q_valid) begin
      check(1'b0, "R7 I/Q lockstep", q_valid, m_valid);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; s_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(m_valid == 1'b0, "R1 reset valid", m_valid, 0);
    check(m_data == 16'd0, "R1 reset data", m_data, 0);
    pending = 0;
    sb.delete();
    rst_n = 1'b1;
  endtask

  // driver: feeds a phase and pushes the expected words
  task automatic run_phase(input string tag, input int a, input int b,
                           input bit gaps, input bit all_chk, input int expv);
    int acc = 0;
    int outs = 0;
    int cyc = 0;
    do_reset();
    while (outs < NOUT) begin
      @(negedge clk);
      if (gaps && (cyc % 3 == 2)) begin
        s_valid = 1'b0; s_data = 16'h7FFF; q_data = 16'h8000;
      end else begin
        s_valid = 1'b1;
        s_data  = (acc % 2 == 0) ? a[15:0] : b[15:0];
        q_data  = ~s_data;
      end
      cyc++;
      @(posedge clk);
      if (s_valid) begin
        acc++;
        if (acc % RATIO == 0) begin
          exp_t e;
          e.chk = all_chk || (outs >= SETTLE);
          e.val = expv[15:0];
          e.tag = tag;
          sb.push_back(e);
          pending = 1;
          outs++;
        end
      end
    end
    @(negedge clk);
    s_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(sb.size() == 0, {tag, " all words seen"}, sb.size(), 0);
  endtask

  initial begin
    run_phase("R1 zero input", 0, 0, 1'b0, 1'b1, 0);
    run_phase("R4 dc positive", 1234, 1234, 1'b0, 1'b0, 1234);
    run_phase("R4 dc negative", -5, -5, 1'b0, 1'b0, -5);
    run_phase("R5 full scale neg", -32768, -32768, 1'b0, 1'b0, -32768);
    run_phase("R5 full scale pos", 32767, 32767, 1'b0, 1'b0, 32767);
    run_phase("R6 half lsb floor pos", 1, 0, 1'b0, 1'b0, 0);
    run_phase("R6 half lsb floor neg", -1, 0, 1'b0, 1'b0, -1);
    run_phase("R3 gaps ignored", -777, -777, 1'b1, 1'b0, -777);
    // R8: output held between pulses
    @(negedge clk);
    begin
      logic [15:0] held;
      held = m_data;
      repeat (20) @(negedge clk);
      check(m_data == held, "R8 data hold", m_data, held);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule